// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Saturating Arithmetic

This block is the integer execution stage for a 32-bit core. Each cycle it can accept one operation: add, subtract, reverse subtract, compare, one of four logical operations, or one of three saturating add or subtract forms. The second operand (`reg_b`) always comes from a register. It is also the destination of the result. The first operand comes either from `reg_a` or from the immediate field. A 5-bit immediate is always sign-extended. A 16-bit immediate is sign-extended for arithmetic operations and zero-extended for logical ones.

The block holds a status register with five flags: zero, sign, carry, overflow and a sticky saturation flag. Each class of operation rewrites only its own subset of these flags. On the clock edge that accepts an operation, the block registers the result, a write-enable for the register file and the new flags. All of them are visible from the following cycle. The register file itself is outside the block.

Top module: `sat_alu`

## Requirements
- R1: ADD (op_code 0) writes reg_b + operand, wrapped to 32 bits. Carry is set when the unsigned sum exceeds 32 bits. Overflow is set when both inputs have the same sign and the result's sign differs from it. Zero and sign follow the result.
- R2: SUB (op_code 1) writes reg_b − operand. Carry means an unsigned borrow (operand > reg_b). Overflow is set when the input signs differ and the result's sign differs from reg_b's sign. Zero and sign follow the result.
- R3: SUBR (op_code 2) writes operand − reg_b. Its carry and overflow follow R2 with the roles exchanged: operand is the minuend and reg_b the subtrahend.
- R4: CMP (op_code 3) sets zero, sign, carry and overflow exactly as SUB would, and never asserts wr_en.
- R5: src_mode selects the first operand. 0 or 3 selects reg_a. 1 selects imm[4:0], sign-extended from bit 4. 2 selects imm[15:0], sign-extended from bit 15 for arithmetic and zero-extended for logical operations.
- R6: OR (4), XOR (6) and NOT (7, result is the complement of the operand) set zero and sign from the result, clear overflow and leave carry unchanged.
- R7: AND (5) with register or 5-bit operands behaves like R6. AND with the 16-bit immediate (src_mode 2) sets only zero from the result, clears sign and overflow, and leaves carry unchanged.
- R8: SATADD (8), SATSUB (9, reg_b − operand) and SATSUBR (10, operand − reg_b) set flags like ADD, SUB and SUBR. On overflow they write 0x7FFFFFFF when the exact result was too large, or 0x80000000 when it was too small. Without overflow they write the exact result.
- R9: The saturation flag is set only by a saturating operation that overflows. Every other operation leaves it unchanged. A high sat_clr clears it at the next edge, unless a saturating overflow is accepted on that same edge, in which case the flag is set.
- R10: result, wr_en and the flags change on the clock edge that samples op_valid high. When op_valid is low, or op_code is 11 to 15, wr_en is low and zero, sign, carry and overflow keep their values.
- R11: After reset, result, wr_en and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| src_mode | input | 2 | First operand source |
| reg_a | input | 32 | First register operand |
| reg_b | input | 32 | Second register operand and destination value |
| imm | input | 16 | Immediate field |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Write result back to destination register |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_cy | output | 1 | Carry / borrow flag |
| flag_ov | output | 1 | Overflow flag |
| flag_sat | output | 1 | Sticky saturation flag |

## Verification
The flags are the block's only state, and a wrong flag value stays at the ports until an operation that owns that flag replaces it. For that reason the tests first load carry, overflow and sign with known values, then run the logical and AND-immediate cases and check that the flags those cases do not own are still intact. A sign or carry swapped on the subtract path shows on the flag outputs one cycle after issue. A clamp in the wrong direction shows on `result` in that same cycle. A saturation flag that fails to stick, or clears when it should not, only shows after a later ordinary operation or an idle cycle, so the tests always follow a saturating overflow with an ordinary operation.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int WIDTH = 32,
  parameter int IMM_S = 5,
  parameter int IMM_L = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [1:0]       src_mode,
  input  logic [WIDTH-1:0] reg_a,
  input  logic [WIDTH-1:0] reg_b,
  input  logic [IMM_L-1:0] imm,
  input  logic             sat_clr,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_cy,
  output logic             flag_ov,
  output logic             flag_sat
);
  localparam int MSB = WIDTH - 1;
  localparam logic [3:0] OP_ADD  = 4'd0, OP_SUB  = 4'd1, OP_SUBR = 4'd2, OP_CMP = 4'd3,
                         OP_OR   = 4'd4, OP_AND  = 4'd5, OP_XOR  = 4'd6, OP_NOT = 4'd7,
                         OP_SADD = 4'd8, OP_SSUB = 4'd9, OP_SSBR = 4'd10;
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic z_q, s_q, cy_q, ov_q, sat_q;
  logic [WIDTH-1:0] res_q;
  logic wr_q;

  wire is_logic = (op_code >= OP_OR) && (op_code <= OP_NOT);
  wire is_sat   = (op_code >= OP_SADD) && (op_code <= OP_SSBR);
  wire known    = (op_code <= OP_SSBR);
  wire accept   = op_valid && known;

  logic [WIDTH-1:0] opnd;
  always_comb begin
    case (src_mode)
      2'd1:    opnd = {{(WIDTH-IMM_S){imm[IMM_S-1]}}, imm[IMM_S-1:0]};
      2'd2:    opnd = is_logic ? {{(WIDTH-IMM_L){1'b0}}, imm}
                               : {{(WIDTH-IMM_L){imm[IMM_L-1]}}, imm};
      default: opnd = reg_a;
    endcase
  end

  wire [WIDTH:0] sum_w  = {1'b0, reg_b} + {1'b0, opnd};
  wire [WIDTH:0] d_ba_w = {1'b0, reg_b} - {1'b0, opnd};
  wire [WIDTH:0] d_ab_w = {1'b0, opnd} - {1'b0, reg_b};

  logic [WIDTH-1:0] raw, final_r;
  logic n_z, n_s, n_cy, n_ov;
  always_comb begin
    raw  = '0;
    n_cy = cy_q;
    n_ov = 1'b0;
    case (op_code)
      OP_ADD, OP_SADD: begin
        raw  = sum_w[MSB:0];
        n_cy = sum_w[WIDTH];
        n_ov = (opnd[MSB] == reg_b[MSB]) && (raw[MSB] != reg_b[MSB]);
      end
      OP_SUB, OP_CMP, OP_SSUB: begin
        raw  = d_ba_w[MSB:0];
        n_cy = d_ba_w[WIDTH];
        n_ov = (opnd[MSB] != reg_b[MSB]) && (raw[MSB] != reg_b[MSB]);
      end
      OP_SUBR, OP_SSBR: begin
        raw  = d_ab_w[MSB:0];
        n_cy = d_ab_w[WIDTH];
        n_ov = (opnd[MSB] != reg_b[MSB]) && (raw[MSB] != opnd[MSB]);
      end
      OP_OR:   raw = reg_b | opnd;
      OP_AND:  raw = reg_b & opnd;
      OP_XOR:  raw = reg_b ^ opnd;
      OP_NOT:  raw = ~opnd;
      default: raw = '0;
    endcase
    n_z = (raw == '0);
    n_s = raw[MSB] && !(op_code == OP_AND && src_mode == 2'd2);
    final_r = raw;
    if (is_sat && n_ov) final_r = raw[MSB] ? MAX_POS : MAX_NEG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      z_q   <= 1'b0;
      s_q   <= 1'b0;
      cy_q  <= 1'b0;
      ov_q  <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      wr_q  <= accept && (op_code != OP_CMP);
      sat_q <= (accept && is_sat && n_ov) || (sat_q && !sat_clr);
      if (accept) begin
        if (op_code != OP_CMP) res_q <= final_r;
        z_q  <= n_z;
        s_q  <= n_s;
        cy_q <= n_cy;
        ov_q <= n_ov;
      end
    end
  end

  assign result   = res_q;
  assign wr_en    = wr_q;
  assign flag_z   = z_q;
  assign flag_s   = s_q;
  assign flag_cy  = cy_q;
  assign flag_ov  = ov_q;
  assign flag_sat = sat_q;

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> !wr_en); // R4
  AST_LOGIC_CLEARS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic) |=> !flag_ov); // R6
  AST_LOGIC_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic) |=> (flag_cy == $past(flag_cy))); // R6
  AST_ANDI_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_AND && src_mode == 2'd2) |=> !flag_s); // R7
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_sat) ##1 flag_ov |-> (result == MAX_POS || result == MAX_NEG)); // R8
  AST_SAT_ONLY_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_sat) |-> $past(op_valid && is_sat)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wr_en && $stable({flag_z, flag_s, flag_cy, flag_ov}))); // R10
endmodule

// File: tb/sat_alu_test.sv
module sat_alu_test;
  localparam int CLK_NS = 10;
  localparam logic [3:0] ADD = 0, SUB = 1, SUBR = 2, CMP = 3, LOR = 4, LAND = 5,
                         LXOR = 6, LNOT = 7, SADD = 8, SSUB = 9, SSBR = 10;

  logic clk = 0, rst_n = 0, op_valid = 0, sat_clr = 0;
  logic [3:0] op_code = 0;
  logic [1:0] src_mode = 0;
  logic [31:0] reg_a = 0, reg_b = 0;
  logic [15:0] imm = 0;
  logic [31:0] result;
  logic wr_en, flag_z, flag_s, flag_cy, flag_ov, flag_sat;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sat_alu uut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_mode(src_mode), .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .sat_clr(sat_clr),
    .result(result), .wr_en(wr_en), .flag_z(flag_z), .flag_s(flag_s),
    .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_sat(flag_sat));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flags packed as {z,s,cy,ov,sat}
  task automatic chk_flags(string req, logic [4:0] exp);
    chk(req, "flags zscvq", {27'd0, flag_z, flag_s, flag_cy, flag_ov, flag_sat}, {27'd0, exp});
  endtask

  task automatic issue(logic [3:0] op, logic [1:0] src, logic [31:0] a, logic [31:0] b, logic [15:0] im);
    @(negedge clk);
    op_code = op; src_mode = src; reg_a = a; reg_b = b; imm = im; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic t_reset();
    chk("R11", "result", result, 0);
    chk("R11", "wr_en", {31'd0, wr_en}, 0);
    chk_flags("R11", 5'b00000);
  endtask

  task automatic t_add();
    issue(ADD, 0, 32'h7FFF_FFFF, 32'h0000_0001, 0);
    chk("R1", "add ovf result", result, 32'h8000_0000);
    chk_flags("R1", 5'b01010);
    chk("R1", "add wr_en", {31'd0, wr_en}, 1);
    issue(ADD, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0);
    chk("R1", "add carry result", result, 0);
    chk_flags("R1", 5'b10100);
  endtask

  task automatic t_sub();
    issue(SUB, 0, 32'd7, 32'd5, 0);
    chk("R2", "sub borrow result", result, 32'hFFFF_FFFE);
    chk_flags("R2", 5'b01100);
    issue(SUB, 0, 32'd1, 32'h8000_0000, 0);
    chk("R2", "sub ovf result", result, 32'h7FFF_FFFF);
    chk_flags("R2", 5'b00010);
    issue(SUBR, 0, 32'd10, 32'd3, 0);
    chk("R3", "subr result", result, 32'd7);
    chk_flags("R3", 5'b00000);
    issue(SUBR, 0, 32'd3, 32'd10, 0);
    chk("R3", "subr borrow result", result, 32'hFFFF_FFF9);
    chk_flags("R3", 5'b01100);
  endtask

  task automatic t_cmp();
    issue(ADD, 0, 32'd1, 32'd1, 0);
    issue(CMP, 0, 32'd4, 32'd4, 0);
    chk("R4", "cmp wr_en", {31'd0, wr_en}, 0);
    chk_flags("R4", 5'b10000);
    issue(CMP, 0, 32'd9, 32'd2, 0);
    chk_flags("R4", 5'b01100);
  endtask

  task automatic t_imm();
    issue(ADD, 1, 0, 32'd1, 16'h001F);
    chk("R5", "imm5 -1 add", result, 0);
    chk_flags("R5", 5'b10100);
    issue(ADD, 2, 0, 0, 16'h8000);
    chk("R5", "imm16 sign ext", result, 32'hFFFF_8000);
    issue(LOR, 2, 0, 0, 16'h8000);
    chk("R5", "imm16 zero ext", result, 32'h0000_8000);
    chk("R5", "logical imm sign", {31'd0, flag_s}, 0);
  endtask

  task automatic t_logic();
    issue(ADD, 0, 32'h8000_0000, 32'h8000_0000, 0);
    chk_flags("R6", 5'b10110);
    issue(LXOR, 0, 32'h8000_0000, 0, 0);
    chk("R6", "xor result", result, 32'h8000_0000);
    chk_flags("R6", 5'b01100);
    issue(LNOT, 0, 32'hFFFF_FFFF, 32'h1234_5678, 0);
    chk("R6", "not result", result, 0);
    chk_flags("R6", 5'b10100);
  endtask

  task automatic t_andi();
    issue(SUB, 0, 32'd7, 32'd5, 0);
    issue(LAND, 2, 0, 32'hFFFF_0000, 16'hFFFF);
    chk("R7", "andi result", result, 0);
    chk_flags("R7", 5'b10100);
    issue(LAND, 0, 32'h8000_0000, 32'hC000_0000, 0);
    chk("R7", "and reg sign", result, 32'h8000_0000);
    chk_flags("R7", 5'b01100);
  endtask

  task automatic t_sat();
    issue(SADD, 0, 32'd1, 32'h7FFF_FFFF, 0);
    chk("R8", "satadd clamp hi", result, 32'h7FFF_FFFF);
    chk("R8", "satadd ov/sat", {30'd0, flag_ov, flag_sat}, 32'd3);
    issue(SSUB, 0, 32'd1, 32'h8000_0000, 0);
    chk("R8", "satsub clamp lo", result, 32'h8000_0000);
    issue(SSBR, 0, 32'h8000_0000, 32'd1, 0);
    chk("R8", "satsubr clamp lo", result, 32'h8000_0000);
    issue(SADD, 0, 32'd2, 32'd3, 0);
    chk("R8", "satadd exact", result, 32'd5);
    chk("R9", "sat stays after clean sat op", {31'd0, flag_sat}, 1);
    issue(ADD, 0, 32'd1, 32'd1, 0);
    chk("R9", "sat sticky after add", {31'd0, flag_sat}, 1);
    @(negedge clk); sat_clr = 1; @(negedge clk); sat_clr = 0;
    chk("R9", "sat cleared", {31'd0, flag_sat}, 0);
    issue(ADD, 0, 32'h7FFF_FFFF, 32'd1, 0);
    chk("R9", "plain ovf no sat", {31'd0, flag_sat}, 0);
    @(negedge clk);
    op_code = SADD; src_mode = 0; reg_a = 1; reg_b = 32'h7FFF_FFFF; op_valid = 1; sat_clr = 1;
    @(negedge clk); op_valid = 0; sat_clr = 0;
    chk("R9", "set wins over clear", {31'd0, flag_sat}, 1);
  endtask

  task automatic t_idle();
    issue(SUB, 0, 32'd7, 32'd5, 0);
    @(negedge clk);
    chk("R10", "idle wr_en", {31'd0, wr_en}, 0);
    chk_flags("R10", 5'b01101);
    issue(4'd13, 0, 32'd1, 32'd1, 0);
    chk("R10", "undefined op wr_en", {31'd0, wr_en}, 0);
    chk_flags("R10", 5'b01101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_add();
    t_sub();
    t_cmp();
    t_imm();
    t_logic();
    t_andi();
    t_sat();
    t_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule